// File: doc/BRIEF.md
# IDE Multiword DMA Strobe Timer

This block paces multiword DMA word transfers to one IDE drive. A 32-bit timing word, which software can read and write, holds four-bit counts for three phases of each transfer. The first phase is a shared select-to-strobe setup. Reads and writes then each have their own strobe pulse width and their own recovery count. Every count is stored as its length minus one, so a field of zero gives a one-cycle phase.

The host raises a request, marked as a read or a write. When the block is idle and multiword mode is selected, it accepts the request and takes a copy of the timing word. It then drives the active-low select, acknowledge and strobe lines through the three phases. When recovery ends, it pulses a done flag for one cycle. Requests wait while a transfer runs.

If the mode bit picks the other DMA type, the block accepts no request and keeps every strobe high.

Top module: `ide_dma_strobe_timer`

## Requirements
- R1: After reset the timing word reads 32'h00077771. The select, acknowledge and both strobes are high, done is low, and req_ready is high.
- R2: Bits 30:21 of the timing word always read as zero, whatever value was written. Bit 31 and bits 20:0 read back as written.
- R3: The setup phase begins in the first cycle after acceptance and lasts (bits 3:0)+1 cycles. During setup, cs_n and dack_n are low and both strobes are high.
- R4: A read (req_write=0) holds rd_n low for (bits 15:12)+1 cycles right after setup. A recovery of (bits 19:16)+1 cycles follows, with rd_n high and the select still low.
- R5: A write (req_write=1) holds wr_n low for (bits 7:4)+1 cycles right after setup. A recovery of (bits 11:8)+1 cycles follows, with wr_n high and the select still low.
- R6: In the cycle after recovery ends, done is high for exactly one cycle. In that same cycle cs_n and dack_n return high and req_ready is high again.
- R7: req_ready is low for as long as a transfer runs. A request held through a transfer is accepted at the edge that ends the done cycle.
- R8: While bit 20 of the timing word is 1, req_ready stays low. No request is accepted, and cs_n, dack_n, rd_n and wr_n stay high.
- R9: Bit 31 has no effect on phase lengths.
- R10: A write to the timing word while a transfer runs, or in the cycle a request is accepted, leaves that transfer's timing unchanged. The new word applies from the next transfer on.
- R11: rd_n and wr_n are never low together. A strobe is low only while cs_n is low. All drive-side outputs come from flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the timing word |
| reg_wdata | input | 32 | Value written to the timing word |
| reg_rdata | output | 32 | Current timing word |
| req_valid | input | 1 | Host transfer request |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_ready | output | 1 | Request accepted at this edge when high together with req_valid |
| done | output | 1 | One-cycle pulse when a transfer completes |
| cs_n | output | 1 | Active-low drive select |
| dack_n | output | 1 | Active-low DMA acknowledge |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Two pairs of events can land on the same clock edge. The first is a timing-word write together with the acceptance of a request. The second is the done cycle together with a new acceptance. The bench raises a register write in the same cycle as a request and checks that the transfer follows the old word while the next one follows the new word. It also holds a request through a whole transfer and checks that select drops again right after the done pulse, with no idle gap.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
  localparam int CW = 32;
  localparam int FW = 4;
  localparam logic [CW-1:0] RST_WORD = 32'h0007_7771;
  localparam logic [CW-1:0] RSV_MASK = 32'h7FE0_0000;
  localparam int MODE_BIT = 20;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_RECOV} phase_e;

  typedef struct packed {
    logic [FW-1:0] rd_rec;
    logic [FW-1:0] rd_pw;
    logic [FW-1:0] wr_rec;
    logic [FW-1:0] wr_pw;
    logic [FW-1:0] setup;
  } timing_t;

  function automatic timing_t decode_timing(input logic [5*FW-1:0] w);
    timing_t t;
    t = timing_t'(w);
    return t;
  endfunction

  // counter load for a phase: field value, phase ends when counter reaches zero
  function automatic logic [FW-1:0] phase_load(input logic [FW-1:0] field);
    return field;
  endfunction

  function automatic logic [CW-1:0] clean_word(input logic [CW-1:0] w);
    return w & ~RSV_MASK;
  endfunction
endpackage

// File: rtl/ide_timing_reg.sv
module ide_timing_reg
  import ide_dma_pkg::*;
#(
  parameter int W = CW,
  parameter logic [W-1:0] RESET_VAL = RST_WORD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL;
    else if (wr_en) q <= clean_word(wdata);
  end
endmodule

// File: rtl/ide_mode_gate.sv
module ide_mode_gate
  import ide_dma_pkg::*;
#(
  parameter int W = CW,
  parameter int SEL_BIT = MODE_BIT
) (
  input  logic [W-1:0] word,
  output logic         mdma_ok
);
  assign mdma_ok = ~word[SEL_BIT];
endmodule

// File: rtl/ide_phase_seq.sv
module ide_phase_seq
  import ide_dma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5*FW-1:0] cfg_fields,
  input  logic            mdma_ok,
  input  logic            req_valid,
  input  logic            req_write,
  output logic            req_ready,
  output phase_e          nxt_phase,
  output logic            nxt_wr,
  output logic            nxt_done,
  output logic            accept_evt,
  output logic            phase_end_evt
);
  phase_e        phase_q;
  logic [FW-1:0] cnt_q, cnt_d;
  logic          wr_q;
  timing_t       snap_q, snap_d;

  assign req_ready     = (phase_q == PH_IDLE) && mdma_ok;
  assign accept_evt    = req_ready && req_valid;
  assign phase_end_evt = (phase_q != PH_IDLE) && (cnt_q == '0);

  always_comb begin
    nxt_phase = phase_q;
    nxt_wr    = wr_q;
    nxt_done  = 1'b0;
    snap_d    = snap_q;
    cnt_d     = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = cnt_q;
        if (accept_evt) begin
          snap_d    = decode_timing(cfg_fields);
          nxt_wr    = req_write;
          nxt_phase = PH_SETUP;
          cnt_d     = phase_load(snap_d.setup);
        end
      end
      PH_SETUP: if (phase_end_evt) begin
        nxt_phase = PH_PULSE;
        cnt_d     = phase_load(wr_q ? snap_q.wr_pw : snap_q.rd_pw);
      end
      PH_PULSE: if (phase_end_evt) begin
        nxt_phase = PH_RECOV;
        cnt_d     = phase_load(wr_q ? snap_q.wr_rec : snap_q.rd_rec);
      end
      PH_RECOV: if (phase_end_evt) begin
        nxt_phase = PH_IDLE;
        nxt_done  = 1'b1;
        cnt_d     = '0;
      end
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      snap_q  <= '0;
    end else begin
      phase_q <= nxt_phase;
      cnt_q   <= cnt_d;
      wr_q    <= nxt_wr;
      snap_q  <= snap_d;
    end
  end
endmodule

// File: rtl/ide_strobe_drv.sv
module ide_strobe_drv
  import ide_dma_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e nxt_phase,
  input  logic   nxt_wr,
  input  logic   nxt_done,
  output logic   cs_n,
  output logic   dack_n,
  output logic   rd_n,
  output logic   wr_n,
  output logic   done
);
  logic sel_d, pulse_d;
  assign sel_d   = (nxt_phase != PH_IDLE);
  assign pulse_d = (nxt_phase == PH_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n   <= 1'b1;
      dack_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      done   <= 1'b0;
    end else begin
      cs_n   <= ~sel_d;
      dack_n <= ~sel_d;
      rd_n   <= ~(pulse_d && !nxt_wr);
      wr_n   <= ~(pulse_d && nxt_wr);
      done   <= nxt_done;
    end
  end
endmodule

// File: rtl/ide_dma_strobe_timer.sv
module ide_dma_strobe_timer
  import ide_dma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          req_ready,
  output logic          done,
  output logic          cs_n,
  output logic          dack_n,
  output logic          rd_n,
  output logic          wr_n
);
  logic [CW-1:0] cfg_q;
  logic          mdma_ok;
  phase_e        nxt_phase;
  logic          nxt_wr, nxt_done;
  logic          accept_evt, phase_end_evt;

  ide_timing_reg #(.W(CW), .RESET_VAL(RST_WORD)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata), .q(cfg_q)
  );

  ide_mode_gate #(.W(CW), .SEL_BIT(MODE_BIT)) u_gate (
    .word(cfg_q), .mdma_ok(mdma_ok)
  );

  ide_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_fields(cfg_q[5*FW-1:0]), .mdma_ok(mdma_ok),
    .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
    .nxt_phase(nxt_phase), .nxt_wr(nxt_wr), .nxt_done(nxt_done),
    .accept_evt(accept_evt), .phase_end_evt(phase_end_evt)
  );

  ide_strobe_drv u_drv (
    .clk(clk), .rst_n(rst_n), .nxt_phase(nxt_phase), .nxt_wr(nxt_wr),
    .nxt_done(nxt_done), .cs_n(cs_n), .dack_n(dack_n), .rd_n(rd_n),
    .wr_n(wr_n), .done(done)
  );

  assign reg_rdata = cfg_q;
endmodule

// File: rtl/ide_dma_strobe_timer_chk.sv
module ide_dma_strobe_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rdata,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        cs_n,
  input logic        dack_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic        accept_evt,
  input logic        phase_end_evt
);
  // R2: reserved field never reads non-zero
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[30:21] == '0);

  // R3: select falls with both strobes still high
  p_setup_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (rd_n && wr_n));

  // R6: done follows a selected cycle and comes with select released
  p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && dack_n && $past(!cs_n)));

  // R6: done lasts a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(phase_end_evt));

  // R7: no ready while a transfer is in flight
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  // R7: acceptance drives select low next cycle
  p_accept_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !cs_n);

  // R8: other DMA type blocks acceptance
  p_mode_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[20] && req_valid) |-> !req_ready);

  // R11: strobes exclusive and only under select
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_strobe_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (!cs_n && !dack_n));
endmodule

bind ide_dma_strobe_timer ide_dma_strobe_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .req_valid(req_valid),
  .req_ready(req_ready), .done(done), .cs_n(cs_n), .dack_n(dack_n),
  .rd_n(rd_n), .wr_n(wr_n), .accept_evt(accept_evt),
  .phase_end_evt(phase_end_evt)
);

// File: tb/ide_dma_strobe_timer_tb.sv
module ide_dma_strobe_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_ready, done, cs_n, dack_n, rd_n, wr_n;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ide_dma_strobe_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .done(done), .cs_n(cs_n), .dack_n(dack_n),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  localparam int NV = 7;
  localparam logic [31:0] V_WORD [NV] = '{32'h0007_7771, 32'h0007_7771,
    32'h0001_2121, 32'h000A_5C73, 32'h000A_5C73, 32'h0000_0000, 32'h0003_5352};
  localparam bit V_WR [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int V_S [NV] = '{2, 2, 2, 4, 4, 1, 3};
  localparam int V_P [NV] = '{8, 8, 3, 6, 8, 1, 6};
  localparam int V_R [NV] = '{8, 8, 2, 11, 13, 1, 4};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [31:0] w);
    reg_wr_en = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // starts and follows one transfer; outputs packed {cs,dack,rd,wr,done,ready}
  task automatic run_xfer(input bit w, input int s, input int p, input int r,
                          input int mid_i, input logic [31:0] mid_word,
                          input bit same, input logic [31:0] same_word,
                          input string tag);
    int total;
    logic [5:0] exp_v;
    logic st;
    total = s + p + r;
    check({tag, " ready before request"}, {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_write = w;
    if (same) begin
      reg_wr_en = 1'b1;
      reg_wdata = same_word;
    end
    @(negedge clk);
    req_valid = 1'b0;
    reg_wr_en = 1'b0;
    for (int i = 0; i <= total; i++) begin
      st = (i >= s && i < s + p) ? 1'b0 : 1'b1;
      exp_v[5] = (i < total) ? 1'b0 : 1'b1;
      exp_v[4] = exp_v[5];
      exp_v[3] = w ? 1'b1 : st;
      exp_v[2] = w ? st : 1'b1;
      exp_v[1] = (i == total);
      exp_v[0] = (i == total);
      check(tag, {26'd0, cs_n, dack_n, rd_n, wr_n, done, req_ready}, {26'd0, exp_v});
      if (i == mid_i) begin
        reg_wr_en = 1'b1;
        reg_wdata = mid_word;
      end
      @(negedge clk);
      reg_wr_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {27'd0, cs_n, dack_n, rd_n, wr_n, done}, {27'd0, 5'b11110});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset word", reg_rdata, 32'h0007_7771);
    check("R1 ready after reset", {31'd0, req_ready}, 32'd1);

    // R3 R4 R5 table of timing words
    for (int v = 0; v < NV; v++) begin
      wr_reg(V_WORD[v]);
      run_xfer(V_WR[v], V_S[v], V_P[v], V_R[v], -1, '0, 1'b0, '0,
               V_WR[v] ? "R3/R5 write vector" : "R3/R4 read vector");
    end

    // R2 reserved bits
    wr_reg(32'hFFFF_FFFF);
    check("R2 reserved readback", reg_rdata, 32'h801F_FFFF);

    // R8 other DMA type, bit 23 also reserved
    wr_reg(32'h0092_1250);
    check("R2 ultra word readback", reg_rdata, 32'h0012_1250);
    req_valid = 1'b1;
    req_write = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R8 blocked", {27'd0, cs_n, dack_n, rd_n, wr_n, req_ready}, {27'd0, 5'b11110});
    end
    req_valid = 1'b0;

    // R9 format bit ignored
    wr_reg(32'h8000_2020);
    check("R2 format bit kept", reg_rdata, 32'h8000_2020);
    run_xfer(1'b1, 1, 3, 1, -1, '0, 1'b0, '0, "R9 format bit write");
    run_xfer(1'b0, 1, 3, 1, -1, '0, 1'b0, '0, "R9 format bit read");

    // R10 write during pulse
    wr_reg(32'h0000_2020);
    run_xfer(1'b0, 1, 3, 1, 2, 32'h000A_5C73, 1'b0, '0, "R10 mid-transfer write");
    check("R10 word updated", reg_rdata, 32'h000A_5C73);
    run_xfer(1'b0, 4, 6, 11, -1, '0, 1'b0, '0, "R10 next transfer new word");

    // R10 write in the acceptance cycle
    run_xfer(1'b1, 4, 8, 13, -1, '0, 1'b1, 32'h0000_2020, "R10 same-cycle write");
    run_xfer(1'b1, 1, 3, 1, -1, '0, 1'b0, '0, "R10 after same-cycle write");

    // R6 R7 held request accepted at the end of the done cycle
    req_valid = 1'b1;
    req_write = 1'b0;
    @(negedge clk);
    repeat (5) @(negedge clk);
    check("R6 done with ready", {30'd0, done, req_ready}, 32'd3);
    @(negedge clk);
    check("R7 back-to-back select", {30'd0, cs_n, req_ready}, 32'd0);
    check("R6 done single cycle", {31'd0, done}, 32'd0);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 second done", {29'd0, done, cs_n, rd_n}, 32'd7);
    @(negedge clk);
    check("R11 idle outputs", {28'd0, cs_n, dack_n, rd_n, wr_n}, 32'hF);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule